// File: doc/BRIEF.md
# MII Management Serial Slave

This block answers a bit-banged management stream on behalf of one or more PHYs. The host drives a management clock (`mdc_i`), a data bit (`mdo_i`) and a direction flag (`dir_i`). The block returns a data bit (`mdi_o`). Everything runs in the `clk_i` domain. A management-clock rising edge is detected by comparing `mdc_i` with its value in the previous `clk_i` cycle, and the protocol advances by exactly one bit on each such edge.

After a start delimiter, the block decodes a 2-bit opcode, a 5-bit PHY address and a 5-bit register address. Each frame field is recognised purely by its bit position. For a read, the block drives one zero turnaround bit and then the addressed 16-bit register, MSB first. For a write, it skips two turnaround bits and collects 16 data bits, then commits them to the register array. A fixed idle tail closes every frame before the next start delimiter is accepted. The register array holds `NUM_PHY` PHYs with 32 registers each. Its only non-zero reset content is the basic status register of PHY 0.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset `mdi_o` is 0, register 1 of PHY 0 holds 16'h502C (bits 14, 12, 5, 3 and 2 set), and every other register holds 0.
- R2: A bit is taken only on a sampling edge: a `clk_i` cycle where `mdc_i` is 1 and was 0 in the previous cycle. Changes of `mdo_i` while `mdc_i` stays high have no effect.
- R3: While waiting, bits of value 1 are ignored. A frame starts with a 0 then a 1, both with `dir_i`=0 (`dir_i`=1 means the host is reading and the block drives). A 1 seen with `dir_i`=1 at the second start bit returns the block to waiting. While waiting, any bit with `dir_i`=1 is ignored.
- R4: The two bits after the start form the opcode, first bit as MSB: 2'b10 is read and 2'b01 is write. Any other opcode returns the block to waiting after the register address, and no data is driven.
- R5: Next come the PHY address (5 bits) and then the register address (5 bits), both MSB first. Together they select entry (phy<<5)|reg of the array.
- R6: On a read, the edge after the register address is a turnaround where `mdi_o` is 0. The 16 edges after it carry the register MSB first, but only on edges where `dir_i`=1; on other edges `mdi_o` is 0 and the frame length is unchanged.
- R7: On a write, the two turnaround bits are ignored whatever their value. The next 16 bits, MSB first, are written to the register in one step after the 16th bit.
- R8: Counting the first opcode bit as 0, the frame ends once the count reaches 31. This leaves 2 idle edges after a read and 1 after a write, whatever their values; the block then waits for a new start.
- R9: A PHY address of `NUM_PHY` or above reads as 0. Writes to such an address are discarded and leave every register unchanged.
- R10: `mdi_o` changes only in the `clk_i` cycle after a sampling edge, and it is 0 outside the read data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdc_i | input | 1 | Management clock from the host, synchronous to clk_i |
| mdo_i | input | 1 | Serial data from the host |
| dir_i | input | 1 | 1 when the host reads (block drives), 0 when the host drives |
| mdi_o | output | 1 | Serial data returned to the host, registered |

## Verification
The hardest paths to reach are the ones where the block must refuse a frame that looks almost valid. These are a second start bit arriving with the direction flag set, and an opcode of 11 or 00. In both cases the rest of a complete read frame for the preset status register is sent with the direction flag held high. A block that accepted the frame would then drive a recognisable non-zero pattern, while the correct block keeps `mdi_o` at 0. Sampling-edge discipline is reached by inverting `mdo_i` in the middle of every high phase of a slowed-down read. Idle tail length is reached by chaining frames with the shortest preamble each frame type allows.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_START,
    ST_OP,
    ST_ADDR,
    ST_TA,
    ST_DATA,
    ST_IDLE
  } mdio_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  // bit positions counted from the first opcode bit
  localparam logic [CNT_W-1:0] OP_LAST    = 5'd1;
  localparam logic [CNT_W-1:0] PHY_LAST   = 5'd6;
  localparam logic [CNT_W-1:0] ADDR_LAST  = 5'd11;
  localparam logic [CNT_W-1:0] WR_TA_LAST = 5'd13;
  localparam logic [CNT_W-1:0] RD_FIRST   = 5'd13;
  localparam logic [CNT_W-1:0] RD_LAST    = 5'd28;
  localparam logic [CNT_W-1:0] WR_LAST    = 5'd29;
  localparam logic [CNT_W-1:0] IDLE_LAST  = 5'd30;

  localparam logic [DATA_W-1:0] CAP_100TX_FD = 16'h4000;
  localparam logic [DATA_W-1:0] CAP_10T_FD   = 16'h1000;
  localparam logic [DATA_W-1:0] AN_DONE      = 16'h0020;
  localparam logic [DATA_W-1:0] AN_ABLE      = 16'h0008;
  localparam logic [DATA_W-1:0] LINK_UP      = 16'h0004;
  localparam logic [DATA_W-1:0] STATUS_RESET =
    CAP_100TX_FD | CAP_10T_FD | AN_DONE | AN_ABLE | LINK_UP;
  localparam int STATUS_PHY = 0;
  localparam int STATUS_REG = 1;

endpackage

// File: rtl/mdio_edge_det.sv
module mdio_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  output logic rise_o
);
  logic mdc_q;

  // reset high: a clock already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mdc_q <= 1'b1;
    else         mdc_q <= mdc_i;
  end

  assign rise_o = mdc_i & ~mdc_q;
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              mdo_i,
  input  logic              dir_i,
  output mdio_state_e       state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        op_o,
  output logic [PHY_AW-1:0] phy_o,
  output logic [REG_AW-1:0] rg_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  mdio_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [1:0]        op_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] rg_q;
  logic [DATA_W-1:0] shift_q;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      cnt_q   <= '0;
      op_q    <= '0;
      phy_q   <= '0;
      rg_q    <= '0;
      shift_q <= '0;
    end else if (sample_i) begin
      unique case (state_q)
        ST_RESET: begin
          if (!mdo_i && !dir_i) begin
            state_q <= ST_START;
            op_q    <= '0;
            phy_q   <= '0;
            rg_q    <= '0;
          end
        end
        ST_START: begin
          if (mdo_i) begin
            if (dir_i) begin
              state_q <= ST_RESET;
            end else begin
              state_q <= ST_OP;
              cnt_q   <= '0;
            end
          end
        end
        ST_OP: begin
          op_q  <= {op_q[0], mdo_i};
          cnt_q <= cnt_inc;
          if (cnt_q == OP_LAST) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (cnt_q <= PHY_LAST) phy_q <= {phy_q[PHY_AW-2:0], mdo_i};
          else                   rg_q  <= {rg_q[REG_AW-2:0], mdo_i};
          cnt_q <= cnt_inc;
          if (cnt_q == ADDR_LAST) state_q <= ST_TA;
        end
        ST_TA: begin
          cnt_q <= cnt_inc;
          case (op_q)
            OP_WRITE: if (cnt_q == WR_TA_LAST) state_q <= ST_DATA;
            OP_READ:  state_q <= ST_DATA;
            default:  state_q <= ST_RESET;
          endcase
        end
        ST_DATA: begin
          cnt_q <= cnt_inc;
          if (op_q == OP_WRITE) begin
            shift_q <= {shift_q[DATA_W-2:0], mdo_i};
            if (cnt_q == WR_LAST) state_q <= ST_IDLE;
          end else if (cnt_q == RD_LAST) begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          cnt_q <= cnt_inc;
          if (cnt_q == IDLE_LAST) state_q <= ST_RESET;
        end
        default: state_q <= ST_RESET;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign op_o    = op_q;
  assign phy_o   = phy_q;
  assign rg_o    = rg_q;
  // commit on the edge that carries the last data bit
  assign we_o    = sample_i && (state_q == ST_DATA) && (op_q == OP_WRITE)
                   && (cnt_q == WR_LAST);
  assign wdata_o = {shift_q[DATA_W-2:0], mdo_i};
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_pkg::*;
#(
  parameter int NUM_PHY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] rg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NUM_REG = 1 << REG_AW;

  logic [DATA_W-1:0] regs_q [NUM_PHY][NUM_REG];

  function automatic logic [DATA_W-1:0] rst_val(input int p, input int r);
    return (p == STATUS_PHY && r == STATUS_REG) ? STATUS_RESET : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PHY; p++)
        for (int r = 0; r < NUM_REG; r++)
          regs_q[p][r] <= rst_val(p, r);
    end else if (we_i) begin
      for (int p = 0; p < NUM_PHY; p++)
        for (int r = 0; r < NUM_REG; r++)
          if (phy_i == PHY_AW'(p) && rg_i == REG_AW'(r))
            regs_q[p][r] <= wdata_i;
    end
  end

  // unmatched addresses (absent PHYs) read as zero
  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PHY; p++)
      for (int r = 0; r < NUM_REG; r++)
        if (phy_i == PHY_AW'(p) && rg_i == REG_AW'(r))
          rdata_o = regs_q[p][r];
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int NUM_PHY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdc_i,
  input  logic mdo_i,
  input  logic dir_i,
  output logic mdi_o
);
  localparam logic [DATA_W-1:0] RD_MSB = {1'b1, {(DATA_W-1){1'b0}}};

  logic              sample;
  mdio_state_e       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        op;
  logic [PHY_AW-1:0] phy;
  logic [REG_AW-1:0] rg;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  rd_off;
  logic              rd_drive;
  logic              mdi_q;

  mdio_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mdc_i  (mdc_i),
    .rise_o (sample)
  );

  mdio_frame_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .mdo_i    (mdo_i),
    .dir_i    (dir_i),
    .state_o  (state),
    .cnt_o    (bit_cnt),
    .op_o     (op),
    .phy_o    (phy),
    .rg_o     (rg),
    .we_o     (wr_en),
    .wdata_o  (wr_data)
  );

  mdio_reg_file #(.NUM_PHY(NUM_PHY)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .phy_i   (phy),
    .rg_i    (rg),
    .wdata_i (wr_data),
    .rdata_o (rd_data)
  );

  assign rd_drive = (state == ST_DATA) && (op == OP_READ) && dir_i;
  assign rd_off   = bit_cnt - RD_FIRST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mdi_q <= 1'b0;
    else if (sample) mdi_q <= rd_drive && |(rd_data & (RD_MSB >> rd_off));
  end

  assign mdi_o = mdi_q;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk
  import mdio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample,
  input logic             mdo_i,
  input logic             dir_i,
  input logic             mdi_o,
  input mdio_state_e      st,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [1:0]       op,
  input logic             wr_en
);
  // R2
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> ($stable(st) && $stable(bit_cnt)));

  // R10
  mdi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(mdi_o));

  // R6
  mdi_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdi_o) |-> ($past(dir_i) && $past(st == ST_DATA) && $past(op == OP_READ)));

  // R3
  start_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_START && sample && mdo_i && dir_i) |=> (st == ST_RESET));

  // R4
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TA && sample && op != OP_READ && op != OP_WRITE) |=> (st == ST_RESET));

  // R8
  idle_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && sample && bit_cnt == IDLE_LAST) |=> (st == ST_RESET));

  // R8
  idle_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> (bit_cnt == RD_LAST + 5'd1 || bit_cnt == IDLE_LAST));

  // R7
  commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (st == ST_IDLE));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sample  (sample),
  .mdo_i   (mdo_i),
  .dir_i   (dir_i),
  .mdi_o   (mdi_o),
  .st      (state),
  .bit_cnt (bit_cnt),
  .op      (op),
  .wr_en   (wr_en)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PHY    = 2;

  logic clk_i  = 1'b0;
  logic rst_ni = 1'b0;
  logic mdc_i  = 1'b0;
  logic mdo_i  = 1'b1;
  logic dir_i  = 1'b0;
  logic mdi_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic [15:0] model [4][32];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mdio_mgmt_slave #(.NUM_PHY(NUM_PHY)) dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mdc_i  (mdc_i),
    .mdo_i  (mdo_i),
    .dir_i  (dir_i),
    .mdi_o  (mdi_o)
  );

  function automatic void push(input logic e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  // scoreboard monitor
  initial begin
    logic  e;
    string t;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (mdi_o !== e) begin
        n_fail++;
        $display("FAIL %s: mdi_o=%b expected %b", t, mdi_o, e);
      end
    end
  end

  task automatic send_bit(input logic d, input logic dr, input int hold,
                          input bit glitch, input bit chk, input logic e,
                          input string t);
    @(negedge clk_i);
    mdo_i = d;
    dir_i = dr;
    mdc_i = 1'b1;
    @(negedge clk_i);
    if (glitch) mdo_i = ~d;
    repeat (hold - 1) @(negedge clk_i);
    if (chk) push(e, t);
    mdc_i = 1'b0;
    repeat (hold) @(negedge clk_i);
    if (chk) push(e, t);
  endtask

  task automatic frame(input logic [1:0] op, input int phy, input int rg,
                       input logic [1:0] ta, input logic [15:0] wd,
                       input logic rd_dir, input int pre, input int hold,
                       input bit glitch, input string t);
    logic [4:0] pa;
    logic [4:0] ra;
    logic       e;
    pa = phy[4:0];
    ra = rg[4:0];
    for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b0, hold, glitch, 1'b1, 1'b0, {t, " R10 idle"});
    send_bit(1'b0, 1'b0, hold, glitch, 1'b1, 1'b0, t);
    send_bit(1'b1, 1'b0, hold, glitch, 1'b1, 1'b0, t);
    send_bit(op[1], 1'b0, hold, glitch, 1'b1, 1'b0, t);
    send_bit(op[0], 1'b0, hold, glitch, 1'b1, 1'b0, t);
    for (int i = 4; i >= 0; i--) send_bit(pa[i], 1'b0, hold, glitch, 1'b1, 1'b0, t);
    for (int i = 4; i >= 0; i--) send_bit(ra[i], 1'b0, hold, glitch, 1'b1, 1'b0, t);
    if (op == 2'b10) begin
      send_bit(1'b1, 1'b1, hold, glitch, 1'b1, 1'b0, {t, " R6 turnaround"});
      for (int i = 15; i >= 0; i--) begin
        e = (rd_dir && phy < NUM_PHY) ? model[phy][rg][i] : 1'b0;
        send_bit(1'b0, rd_dir, hold, glitch, 1'b1, e, t);
      end
    end else if (op == 2'b01) begin
      send_bit(ta[1], 1'b0, hold, glitch, 1'b1, 1'b0, t);
      send_bit(ta[0], 1'b0, hold, glitch, 1'b1, 1'b0, t);
      for (int i = 15; i >= 0; i--) send_bit(wd[i], 1'b0, hold, glitch, 1'b1, 1'b0, t);
      if (phy < NUM_PHY) model[phy][rg] = wd;
    end else begin
      for (int i = 0; i < 17; i++) send_bit(1'b1, 1'b1, hold, glitch, 1'b1, 1'b0, t);
    end
  endtask

  task automatic rd(input int phy, input int rg, input int pre, input string t);
    frame(2'b10, phy, rg, 2'b10, 16'h0, 1'b1, pre, 1, 1'b0, t);
  endtask

  task automatic wr(input int phy, input int rg, input logic [15:0] d,
                    input logic [1:0] ta, input int pre, input string t);
    frame(2'b01, phy, rg, ta, d, 1'b0, pre, 1, 1'b0, t);
  endtask

  task automatic aborted_start(input string t);
    logic [10:0] body;
    send_bit(1'b1, 1'b0, 1, 1'b0, 1'b1, 1'b0, t);
    send_bit(1'b1, 1'b0, 1, 1'b0, 1'b1, 1'b0, t);
    send_bit(1'b0, 1'b0, 1, 1'b0, 1'b1, 1'b0, t);
    send_bit(1'b1, 1'b1, 1, 1'b0, 1'b1, 1'b0, t);
    // remainder of a read of PHY 0 register 1, host still reading
    body = {2'b10, 5'd0, 4'b0000};
    for (int i = 10; i >= 0; i--) send_bit(body[i], 1'b1, 1, 1'b0, 1'b1, 1'b0, t);
    send_bit(1'b1, 1'b1, 1, 1'b0, 1'b1, 1'b0, t);
    for (int i = 0; i < 17; i++) send_bit(1'b1, 1'b1, 1, 1'b0, 1'b1, 1'b0, t);
  endtask

  initial begin
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 32; r++)
        model[p][r] = 16'h0;
    model[0][1] = 16'h502C;

    repeat (5) @(negedge clk_i);
    n_chk++;
    if (mdi_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: mdi_o=%b expected 0", mdi_o);
    end
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    rd(0, 1, 2, "R1 status preset");
    rd(0, 2, 2, "R1 other register zero");
    rd(1, 1, 2, "R1 preset only on PHY 0");

    wr(0, 5, 16'hA5C3, 2'b10, 2, "R7 write p0r5");
    wr(1, 5, 16'h3C96, 2'b10, 2, "R7 write p1r5");
    wr(1, 31, 16'h8001, 2'b10, 2, "R7 write p1r31");
    rd(0, 5, 2, "R5 index p0r5");
    rd(1, 5, 2, "R5 index p1r5");
    rd(1, 31, 2, "R5 index p1r31");

    wr(0, 9, 16'h1234, 2'b01, 2, "R7 turnaround value ignored");
    rd(0, 9, 2, "R7 readback after odd turnaround");

    wr(3, 5, 16'hBEEF, 2'b10, 2, "R9 write absent PHY");
    rd(3, 5, 2, "R9 absent PHY reads zero");
    rd(1, 5, 2, "R9 no alias to PHY 1");

    frame(2'b10, 0, 5, 2'b10, 16'h0, 1'b1, 2, 4, 1'b1, "R2 glitch while clock high");

    frame(2'b10, 0, 1, 2'b10, 16'h0, 1'b0, 2, 1, 1'b0, "R6 host not reading");
    rd(0, 1, 2, "R6 read after undriven frame");

    frame(2'b11, 0, 1, 2'b10, 16'h0, 1'b1, 2, 1, 1'b0, "R4 opcode 11 ignored");
    frame(2'b00, 0, 1, 2'b10, 16'h0, 1'b1, 2, 1, 1'b0, "R4 opcode 00 ignored");
    rd(0, 1, 2, "R4 read after bad opcodes");

    aborted_start("R3 direction at second start bit");
    rd(0, 1, 2, "R3 read after aborted start");

    wr(0, 12, 16'h0F0F, 2'b10, 2, "R8 write before short gap");
    rd(0, 12, 1, "R8 one idle edge after write");
    rd(0, 1, 2, "R8 two idle edges after read");

    send_bit(1'b1, 1'b0, 1, 1'b0, 1'b1, 1'b0, "R10 idle after last read");
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule